// File: doc/BRIEF.md
# Real-Time Clock with Alarm, Watchdog and Interrupt Merge

This block keeps a BCD calendar (seconds through two-digit year) inside a synchronous design. It counts pulses of a 32.768 kHz reference enable (`ref_tick`, one system-clock cycle wide per reference period) down to a single-cycle one-second tick. It compares the advancing time against programmable alarm fields and counts a watchdog down in whole seconds. It also watches an external power-fail level. Each of those three sources sets a sticky flag. The enabled flags are merged onto one interrupt pin, which is driven either as an active-high push-pull output or as an active-low open-drain output.

Software reaches everything through a flat byte-wide register port. Writes take effect at the clock edge. Reads are combinational from `reg_addr`, and a read strobe on the flag register clears the flags at the next edge. Register map (index: content):

- 0 to 5: seconds, minutes, hours, date, month, year, all BCD.
- 6 to 9: alarm seconds, minutes, hours, date.
- 10: alarm mode in bits [2:0], arm bit in bit 3.
- 11: watchdog reload value (write) and current count (read).
- 12: interrupt enables in bits [2:0] (alarm, watchdog, power-fail) and the drive-style bit in bit 3.
- 13: flags in bits [2:0], same order as the enables.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The second tick is a single-cycle pulse raised on every REF_PER_SEC-th `ref_tick` pulse. A write to register 0 restarts the division, so the first tick after it arrives on the REF_PER_SEC-th reference pulse following the write.
- R2: On each tick, seconds and minutes roll from 59 to 00 and hours from 23 to 00, each carrying into the next field. All values stay in BCD.
- R3: The date rolls to 01 after the last day of the month. That last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the two-digit year is divisible by four and on 28 otherwise.
- R4: Month rolls from 12 to 01 with a carry into the year. The year rolls from 99 to 00.
- R5: A write to any of registers 0 to 5 loads that field in BCD. The tick arriving in the same cycle is dropped, so no field advances in that cycle.
- R6: While the arm bit (register 10 bit 3) is 1, an alarm event occurs one cycle after each tick in which the time matches. Matching depends on the mode. Mode 1 matches every second. Mode 2 matches on seconds. Mode 3 matches on seconds and minutes. Mode 4 matches on seconds, minutes and hours. Modes 5 to 7 never match. In modes 1 to 4 the arm bit stays set.
- R7: Mode 0 is a one-shot. It matches seconds, minutes, hours and date, and the event clears the arm bit, so it fires only once.
- R8: A write to register 11 loads both the timeout and the count. Each tick decrements a nonzero count, and the step from 1 to 0 raises the watchdog event. The count then rests at 0 until the next write. A timeout of 0 disables the watchdog.
- R9: A rising edge on `pwr_fail` raises the power-fail event once. A level held high raises no further event.
- R10: Flags (register 13: bit 0 alarm, bit 1 watchdog, bit 2 power-fail) stay set until a read strobe on register 13. That read returns the flags as they were before clearing. An event in the same cycle as the clear leaves its flag set.
- R11: With register 12 bit 3 set to 1, `irq_oe` is 1 and `irq_o` is 1 exactly when some flag has its enable bit (register 12 bits [2:0]) set.
- R12: With register 12 bit 3 set to 0, `irq_o` is always 0. `irq_oe` is 1 exactly while an enabled flag is set, and otherwise the pin is released.
- R13: After reset the time reads 00:00:00, date 01, month 01, year 00. All alarm, watchdog, control and flag registers read 0, and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| pwr_fail | input | 1 | Power-monitor level, synchronous, active high |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears flags at index 13) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Interrupt pin output value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench targets several calendar edges: the leap-day step at the end of February, the non-leap jump to 01 March, and the full rollover from 31 December 99. A design with a wrong month table or a wrong divisibility test lands on the wrong date. It also lines a minutes write up exactly with a tick edge. A design that let the tick through would show the seconds one step ahead. It checks that a one-shot alarm disarms itself while a periodic one stays armed, that a watchdog at timeout zero never fires, and that a power-fail level held high flags only once. In open-drain mode the pin must never drive a one. A polarity or drive mix-up there shows at once in the sampled `irq_o`/`irq_oe` pair, which a cycle-level reference model checks on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W = 8;
  localparam int NSRC   = 3;

  localparam logic [3:0] RA_SEC    = 4'd0;
  localparam logic [3:0] RA_MIN    = 4'd1;
  localparam logic [3:0] RA_HOUR   = 4'd2;
  localparam logic [3:0] RA_DATE   = 4'd3;
  localparam logic [3:0] RA_MONTH  = 4'd4;
  localparam logic [3:0] RA_YEAR   = 4'd5;
  localparam logic [3:0] RA_ASEC   = 4'd6;
  localparam logic [3:0] RA_AMIN   = 4'd7;
  localparam logic [3:0] RA_AHOUR  = 4'd8;
  localparam logic [3:0] RA_ADATE  = 4'd9;
  localparam logic [3:0] RA_AMODE  = 4'd10;
  localparam logic [3:0] RA_WDOG   = 4'd11;
  localparam logic [3:0] RA_ICTL   = 4'd12;
  localparam logic [3:0] RA_FLAGS  = 4'd13;

  typedef enum logic [2:0] {
    AM_ONCE   = 3'd0,
    AM_SECOND = 3'd1,
    AM_MINUTE = 3'd2,
    AM_HOUR   = 3'd3,
    AM_DAY    = 3'd4
  } alarm_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] year;
  } rtc_time_t;

  // BCD increment of a two-digit value (no wrap handling)
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of a month, both inputs and result in BCD
  function automatic logic [7:0] month_end(input logic [7:0] mo, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mo)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // alarm comparison per mode
  function automatic logic alarm_match(input logic [2:0] mode,
                                       input logic [7:0] s,  input logic [7:0] m,
                                       input logic [7:0] h,  input logic [7:0] d,
                                       input logic [7:0] as, input logic [7:0] am,
                                       input logic [7:0] ah, input logic [7:0] ad);
    logic es, em, eh, ed;
    es = (s == as); em = (m == am); eh = (h == ah); ed = (d == ad);
    case (mode)
      AM_ONCE:   return es & em & eh & ed;
      AM_SECOND: return 1'b1;
      AM_MINUTE: return es;
      AM_HOUR:   return es & em;
      AM_DAY:    return es & em & eh;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int REF_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic restart,
  output logic sec_tick
);
  localparam int CW = (REF_PER_SEC > 2) ? $clog2(REF_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign sec_tick = ref_tick & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (ref_tick) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [3:0] wr_sel,
  input  logic [7:0] wr_data,
  output rtc_time_t  now,
  output logic       advance
);
  rtc_time_t t_q, t_nx;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;

  assign advance = tick & ~wr_en;

  always_comb begin
    s_wrap  = (t_q.sec   == 8'h59);
    m_wrap  = (t_q.min   == 8'h59);
    h_wrap  = (t_q.hour  == 8'h23);
    d_wrap  = (t_q.date  == month_end(t_q.month, t_q.year));
    mo_wrap = (t_q.month == 8'h12);
    y_wrap  = (t_q.year  == 8'h99);
    t_nx = t_q;
    t_nx.sec = s_wrap ? 8'h00 : bcd_step(t_q.sec);
    if (s_wrap) begin
      t_nx.min = m_wrap ? 8'h00 : bcd_step(t_q.min);
      if (m_wrap) begin
        t_nx.hour = h_wrap ? 8'h00 : bcd_step(t_q.hour);
        if (h_wrap) begin
          t_nx.date = d_wrap ? 8'h01 : bcd_step(t_q.date);
          if (d_wrap) begin
            t_nx.month = mo_wrap ? 8'h01 : bcd_step(t_q.month);
            if (mo_wrap) t_nx.year = y_wrap ? 8'h00 : bcd_step(t_q.year);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, date: 8'h01, month: 8'h01, year: 8'h00};
    end else if (wr_en) begin
      case (wr_sel)
        RA_SEC:   t_q.sec   <= wr_data;
        RA_MIN:   t_q.min   <= wr_data;
        RA_HOUR:  t_q.hour  <= wr_data;
        RA_DATE:  t_q.date  <= wr_data;
        RA_MONTH: t_q.month <= wr_data;
        default:  t_q.year  <= wr_data;
      endcase
    end else if (tick) begin
      t_q <= t_nx;
    end
  end

  assign now = t_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] al_sec,
  output logic [7:0] al_min,
  output logic [7:0] al_hour,
  output logic [7:0] al_date,
  output logic [2:0] mode,
  output logic       armed,
  output logic       hit,
  output logic       once_mode,
  output logic       cfg_wr
);
  logic tick_d;

  assign cfg_wr    = wr_en & (wr_addr == RA_AMODE);
  assign once_mode = (mode == AM_ONCE);
  assign hit = tick_d & armed &
               alarm_match(mode, now_sec, now_min, now_hour, now_date,
                           al_sec, al_min, al_hour, al_date);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_d  <= 1'b0;
      al_sec  <= 8'h00;
      al_min  <= 8'h00;
      al_hour <= 8'h00;
      al_date <= 8'h00;
      mode    <= 3'd0;
      armed   <= 1'b0;
    end else begin
      tick_d <= tick;
      if (wr_en) begin
        case (wr_addr)
          RA_ASEC:  al_sec  <= wr_data;
          RA_AMIN:  al_min  <= wr_data;
          RA_AHOUR: al_hour <= wr_data;
          RA_ADATE: al_date <= wr_data;
          default: ;
        endcase
      end
      if (cfg_wr) begin
        mode  <= wr_data[2:0];
        armed <= wr_data[3];
      end else if (hit && once_mode) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] timeout,
  output logic             fire
);
  logic running;

  assign running = (timeout != '0) & (count != '0);
  assign fire    = tick & ~reload & running & (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      timeout <= '0;
    end else if (reload) begin
      count   <= reload_val;
      timeout <= reload_val;
    end else if (tick && running) begin
      count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_pkg::*;
#(
  parameter int REF_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       pwr_fail,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o,
  output logic       irq_oe
);
  localparam int WD_W = BYTE_W;

  rtc_time_t        now;
  logic             sec_tick, cal_adv, time_wr;
  logic [7:0]       al_sec, al_min, al_hour, al_date;
  logic [2:0]       al_mode;
  logic             al_armed, alarm_hit, al_once, al_cfg_wr;
  logic [WD_W-1:0]  wd_count, wd_tmo;
  logic             wd_fire, wd_wr;
  logic             pf_d, pf_event;
  logic [NSRC-1:0]  int_en, flags, src_event;
  logic             drive_pp, flag_clr, irq_active;

  assign time_wr  = reg_we & (reg_addr <= RA_YEAR);
  assign wd_wr    = reg_we & (reg_addr == RA_WDOG);
  assign flag_clr = reg_re & (reg_addr == RA_FLAGS);

  rtc_prescaler #(.REF_PER_SEC(REF_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .restart(reg_we & (reg_addr == RA_SEC)), .sec_tick(sec_tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .wr_en(time_wr), .wr_sel(reg_addr), .wr_data(reg_wdata),
    .now(now), .advance(cal_adv)
  );

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .now_sec(now.sec), .now_min(now.min), .now_hour(now.hour), .now_date(now.date),
    .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .al_date(al_date),
    .mode(al_mode), .armed(al_armed), .hit(alarm_hit), .once_mode(al_once),
    .cfg_wr(al_cfg_wr)
  );

  rtc_watchdog #(.CNT_W(WD_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .reload(wd_wr),
    .reload_val(reg_wdata), .count(wd_count), .timeout(wd_tmo), .fire(wd_fire)
  );

  assign pf_event  = pwr_fail & ~pf_d;
  assign src_event = {pf_event, wd_fire, alarm_hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_d     <= 1'b0;
      flags    <= '0;
      int_en   <= '0;
      drive_pp <= 1'b0;
    end else begin
      pf_d  <= pwr_fail;
      flags <= (flag_clr ? '0 : flags) | src_event;
      if (reg_we && reg_addr == RA_ICTL) begin
        int_en   <= reg_wdata[NSRC-1:0];
        drive_pp <= reg_wdata[3];
      end
    end
  end

  assign irq_active = |(flags & int_en);
  assign irq_o      = drive_pp ? irq_active : 1'b0;
  assign irq_oe     = drive_pp ? 1'b1 : irq_active;

  always_comb begin
    case (reg_addr)
      RA_SEC:   reg_rdata = now.sec;
      RA_MIN:   reg_rdata = now.min;
      RA_HOUR:  reg_rdata = now.hour;
      RA_DATE:  reg_rdata = now.date;
      RA_MONTH: reg_rdata = now.month;
      RA_YEAR:  reg_rdata = now.year;
      RA_ASEC:  reg_rdata = al_sec;
      RA_AMIN:  reg_rdata = al_min;
      RA_AHOUR: reg_rdata = al_hour;
      RA_ADATE: reg_rdata = al_date;
      RA_AMODE: reg_rdata = {4'b0, al_armed, al_mode};
      RA_WDOG:  reg_rdata = wd_count;
      RA_ICTL:  reg_rdata = {4'b0, drive_pp, int_en};
      RA_FLAGS: reg_rdata = {5'b0, flags};
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_o,
  input logic       irq_oe,
  input logic       drive_pp,
  input logic       sec_tick,
  input logic [7:0] sec_bcd,
  input logic       alarm_hit,
  input logic       alarm_once,
  input logic       alarm_arm,
  input logic       alarm_cfg_wr,
  input logic       wd_fire,
  input logic [7:0] wd_tmo,
  input logic [2:0] flags,
  input logic       flag_clr
);
  // R12
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_pp |-> !irq_o);

  // R11
  pp_always_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_pp |-> irq_oe);

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R2
  sec_bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_bcd <= 8'h59) && (sec_bcd[3:0] <= 4'h9));

  // R7
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && alarm_once && !alarm_cfg_wr) |=> !alarm_arm);

  // R8
  wd_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |-> (wd_tmo != 8'h00));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((flags & $past(flags)) == $past(flags)));

  // R10
  flag_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flags[0]);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .irq_oe(irq_oe), .drive_pp(drive_pp),
  .sec_tick(sec_tick), .sec_bcd(now.sec), .alarm_hit(alarm_hit),
  .alarm_once(al_once), .alarm_arm(al_armed), .alarm_cfg_wr(al_cfg_wr),
  .wd_fire(wd_fire), .wd_tmo(wd_tmo), .flags(flags), .flag_clr(flag_clr)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_o, irq_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit model_ok = 1'b0;

  always #4 clk = ~clk;

  rtc_alarm_irq #(.REF_PER_SEC(DIV)) u_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pwr_fail(pwr_fail),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // ---------------- behavioural reference model (binary integers) -------------
  int m_t[6];          // sec, min, hour, date, month, year
  int m_a[4];          // alarm sec, min, hour, date
  int m_mode, m_arm, m_en, m_pp, m_flags, m_wc, m_wt, m_pc, m_tickd, m_pfd;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit m_match();
    bit s, mi, h, d;
    s = m_t[0] == m_a[0]; mi = m_t[1] == m_a[1];
    h = m_t[2] == m_a[2]; d = m_t[3] == m_a[3];
    case (m_mode)
      0: return s && mi && h && d;
      1: return 1'b1;
      2: return s;
      3: return s && mi;
      4: return s && mi && h;
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_second();
    m_t[0]++;
    if (m_t[0] < 60) return;
    m_t[0] = 0; m_t[1]++;
    if (m_t[1] < 60) return;
    m_t[1] = 0; m_t[2]++;
    if (m_t[2] < 24) return;
    m_t[2] = 0; m_t[3]++;
    if (m_t[3] <= mdays(m_t[4], m_t[5])) return;
    m_t[3] = 1; m_t[4]++;
    if (m_t[4] <= 12) return;
    m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = '{0, 0, 0, 1, 1, 0};
      m_a = '{0, 0, 0, 0};
      m_mode = 0; m_arm = 0; m_en = 0; m_pp = 0; m_flags = 0;
      m_wc = 0; m_wt = 0; m_pc = 0; m_tickd = 0; m_pfd = 0;
      model_ok = 1'b1;
    end else begin
      int ev, tk, a;
      a = int'(reg_addr);
      ev = 0;
      if (m_tickd != 0 && m_arm != 0 && m_match()) ev |= 1;
      tk = (ref_tick && m_pc == DIV - 1) ? 1 : 0;
      if (reg_we && a == 11) begin
        m_wt = int'(reg_wdata); m_wc = m_wt;
      end else if (tk != 0 && m_wt != 0 && m_wc != 0) begin
        if (m_wc == 1) ev |= 2;
        m_wc--;
      end
      if (pwr_fail && m_pfd == 0) ev |= 4;
      m_pfd = pwr_fail ? 1 : 0;
      if (reg_re && a == 13) m_flags = 0;
      m_flags |= ev;
      if (reg_we && a == 10) begin
        m_mode = int'(reg_wdata[2:0]); m_arm = int'(reg_wdata[3]);
      end else if ((ev & 1) != 0 && m_mode == 0) begin
        m_arm = 0;
      end
      if (reg_we && a == 12) begin
        m_en = int'(reg_wdata[2:0]); m_pp = int'(reg_wdata[3]);
      end
      if (reg_we && a >= 6 && a <= 9) m_a[a - 6] = b2i(reg_wdata);
      if (reg_we && a <= 5) m_t[a] = b2i(reg_wdata);
      else if (tk != 0) m_second();
      if (reg_we && a == 0) m_pc = 0;
      else if (ref_tick) m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
      m_tickd = tk;
    end
  end

  function automatic logic [7:0] m_rd(input int a);
    if (a <= 5) return i2b(m_t[a]);
    if (a <= 9) return i2b(m_a[a - 6]);
    case (a)
      10: return 8'(m_arm * 8 + m_mode);
      11: return 8'(m_wc);
      12: return 8'(m_pp * 8 + m_en);
      13: return 8'(m_flags);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R1";
    if (a <= 2) return "R2";
    if (a == 3) return "R3";
    if (a <= 5) return "R4";
    if (a <= 10) return "R6";
    if (a == 11) return "R8";
    if (a == 13) return "R10";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && model_ok) begin
      bit act_i;
      act_i = (m_flags & m_en) != 0;
      chk(tag_of(int'(reg_addr)), reg_rdata, m_rd(int'(reg_addr)));
      if (m_pp != 0) begin
        chk("R11", {6'b0, irq_oe, irq_o}, {6'b0, 1'b1, act_i});
      end else begin
        chk("R12", {6'b0, irq_oe, irq_o}, {6'b0, act_i, 1'b0});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers -------------------------------------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                          input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] sc);
    ref_tick = 1'b0;
    wr(4'd5, yr); wr(4'd4, mo); wr(4'd3, dt);
    wr(4'd2, hr); wr(4'd1, mi); wr(4'd0, sc);
  endtask

  task automatic run(input int n);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    rd(4'd0, v);  chk("R13", v, 8'h00);
    rd(4'd3, v);  chk("R13", v, 8'h01);
    rd(4'd4, v);  chk("R13", v, 8'h01);
    rd(4'd13, v); chk("R13", v, 8'h00);
    chk("R13", {6'b0, irq_oe, irq_o}, 8'h00);

    // R1 tick after exactly DIV reference pulses
    wr(4'd0, 8'h00);
    run(3);
    rd(4'd0, v); chk("R1", v, 8'h00);
    run(1);
    rd(4'd0, v); chk("R1", v, 8'h01);

    // R3 leap-year February, R2 hour carry
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(5);
    rd(4'd3, v); chk("R3", v, 8'h29);
    rd(4'd4, v); chk("R3", v, 8'h02);
    rd(4'd2, v); chk("R2", v, 8'h00);
    rd(4'd1, v); chk("R2", v, 8'h00);

    // R3 non-leap February
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(5);
    rd(4'd3, v); chk("R3", v, 8'h01);
    rd(4'd4, v); chk("R3", v, 8'h03);

    // R3 thirty-day month
    set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    run(5);
    rd(4'd3, v); chk("R3", v, 8'h01);
    rd(4'd4, v); chk("R3", v, 8'h05);

    // R4 full rollover
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    run(5);
    rd(4'd5, v); chk("R4", v, 8'h00);
    rd(4'd4, v); chk("R4", v, 8'h01);
    rd(4'd3, v); chk("R4", v, 8'h01);

    // R5 write lands on the tick edge: tick dropped
    set_time(8'h10, 8'h06, 8'h15, 8'h08, 8'h20, 8'h10);
    ref_tick = 1'b1;
    repeat (2) @(negedge clk);
    wr(4'd1, 8'h42);
    ref_tick = 1'b0;
    rd(4'd0, v); chk("R5", v, 8'h10);
    rd(4'd1, v); chk("R5", v, 8'h42);

    // R6 periodic per-minute alarm, R11 push-pull, R10 clear on read
    rd(4'd13, v);
    wr(4'd6, 8'h30);
    wr(4'd10, 8'h0A);
    wr(4'd12, 8'h09);
    set_time(8'h10, 8'h06, 8'h15, 8'h08, 8'h20, 8'h28);
    run(12);
    chk("R11", {6'b0, irq_oe, irq_o}, 8'h03);
    rd(4'd13, v); chk("R6", v, 8'h01);
    rd(4'd13, v); chk("R10", v, 8'h00);
    chk("R11", {6'b0, irq_oe, irq_o}, 8'h02);
    rd(4'd10, v); chk("R6", v, 8'h0A);

    // R7 one-shot alarm disarms itself
    wr(4'd6, 8'h05); wr(4'd7, 8'h00); wr(4'd8, 8'h00); wr(4'd9, 8'h01);
    wr(4'd10, 8'h08);
    set_time(8'h10, 8'h06, 8'h01, 8'h00, 8'h00, 8'h04);
    run(12);
    rd(4'd10, v); chk("R7", v, 8'h00);
    rd(4'd13, v); chk("R7", v, 8'h01);

    // R8 watchdog timeout, then disabled by zero
    wr(4'd12, 8'h0A);
    wr(4'd11, 8'h03);
    run(20);
    chk("R8", {6'b0, irq_oe, irq_o}, 8'h03);
    rd(4'd11, v); chk("R8", v, 8'h00);
    rd(4'd13, v); chk("R8", v, 8'h02);
    wr(4'd11, 8'h00);
    run(20);
    rd(4'd13, v); chk("R8", v, 8'h00);

    // R9 power-fail edge, R12 open-drain drive
    wr(4'd12, 8'h04);
    @(negedge clk); pwr_fail = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", {6'b0, irq_oe, irq_o}, 8'h02);
    rd(4'd13, v); chk("R9", v, 8'h04);
    repeat (3) @(negedge clk);
    rd(4'd13, v); chk("R9", v, 8'h00);
    chk("R12", {6'b0, irq_oe, irq_o}, 8'h00);
    pwr_fail = 1'b0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule